// File: doc/BRIEF.md
# Receive buffer address override unit

This block sits in the write-address path of a receive DMA engine. Software programs one 32-bit configuration word over a simple register write/read port. The word carries a 4-bit override value and a 4-bit enable field. For every receive data-buffer write address the DMA presents, each enabled position among the top four address bits is replaced by the programmed value. Disabled positions and the whole lower address pass straight through.

Software writes land in a shadow copy, and reads return that copy. A separate working copy drives the address path. The working copy follows the shadow whenever no receive packet is in progress, and it is loaded on the cycle a packet-start strobe arrives. Inside a packet it is frozen. Every beat of a packet therefore sees one mapping, even when software reprograms the word part way through. The next packet picks up the new word.

Top module: `rx_addr_override`

## Requirements
- R1: After an asynchronous reset (rst_ni low), the read data is all zeros and addr_o equals addr_i.
- R2: A write stores wdata bits 31:28 as the override value and bits 3:0 as the enables. reg_rdata_o returns those fields at the same positions, from the cycle after the write.
- R3: While enable bit n (n = 0..3) of the working copy is set, addr_o bit 28+n equals override value bit n, which is register bit 28+n.
- R4: While enable bit n of the working copy is clear, addr_o bit 28+n equals addr_i bit 28+n.
- R5: Register bits 27:4 always read as zero, and the values written to them have no effect on the stored fields or on addr_o.
- R6: A write made while a packet is active leaves the mapping applied to the rest of that packet unchanged, up to and including the beat on which pkt_end_i is high.
- R7: When no packet is active, addr_o uses the shadow contents of the current cycle. The first packet started after a write uses the written word.
- R8: During a packet, reg_rdata_o returns the most recently written word, not the frozen working copy.
- R9: The packet-active state is set by pkt_start_i and cleared by pkt_end_i. When both are high in one cycle, the old packet ends and a new one starts. The new packet loads the current shadow, and the state stays active.
- R10: A write in the same cycle as pkt_start_i does not affect the packet being started. That packet uses the shadow contents held before the write.
- R11: addr_o bits 27:0 always equal addr_i bits 27:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (shadow copy) |
| pkt_start_i | input | 1 | Receive packet start strobe |
| pkt_end_i | input | 1 | Receive packet end strobe |
| addr_i | input | 32 | Buffer write address from the DMA |
| addr_o | output | 32 | Buffer write address after override |

## Verification
The override is tried with all enables set, with alternating enables, and with enables clear. Each pattern uses all-zero, all-one and random addresses, which separates forced bits from passed-through bits in both polarities. A word written with reserved bits set and fields clear shows whether reserved bits leak into storage. Writes are placed in idle time, in the middle of a packet, in the cycle of a packet start, and ahead of a back-to-back end-and-start. These placements tell apart a mapping that is frozen correctly from one that updates early, updates late, or drops the new packet.

// File: rtl/rxao_pkg.sv
package rxao_pkg;
  localparam int REG_W   = 32;
  localparam int OVR_W   = 4;
  localparam int VAL_LSB = REG_W - OVR_W;
  localparam int EN_LSB  = 0;

  typedef struct packed {
    logic [OVR_W-1:0] val;
    logic [OVR_W-1:0] en;
  } ovr_cfg_t;
endpackage

// File: rtl/rxao_cfg_reg.sv
module rxao_cfg_reg
  import rxao_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ovr_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  ovr_cfg_t cfg_q;
  logic     unused_rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.val <= wdata_i[VAL_LSB +: OVR_W];
      cfg_q.en  <= wdata_i[EN_LSB +: OVR_W];
    end
  end

  assign unused_rsvd = ^wdata_i[VAL_LSB-1:EN_LSB+OVR_W];
  assign cfg_o       = cfg_q;

  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b >= VAL_LSB) begin : g_val
      assign rdata_o[b] = cfg_q.val[b-VAL_LSB];
    end else if (b >= EN_LSB && b < EN_LSB + OVR_W) begin : g_en
      assign rdata_o[b] = cfg_q.en[b-EN_LSB];
    end else begin : g_rsvd
      assign rdata_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rxao_pkt_track.sv
module rxao_pkt_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o
);
  logic busy_q;

  // end handled before start when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= start_i | (busy_q & ~end_i);
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rxao_cfg_hold.sv
module rxao_cfg_hold
  import rxao_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  ovr_cfg_t shadow_i,
  output ovr_cfg_t eff_o,
  output ovr_cfg_t act_o
);
  ovr_cfg_t act_q;

  assign eff_o = load_i ? shadow_i : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= eff_o;
  end

  assign act_o = act_q;
endmodule

// File: rtl/rxao_addr_mux.sv
module rxao_addr_mux
  import rxao_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ovr_cfg_t          cfg_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OVR_LSB = ADDR_W - OVR_W;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b >= OVR_LSB) begin : g_ovr
      assign addr_o[b] = cfg_i.en[b-OVR_LSB] ? cfg_i.val[b-OVR_LSB] : addr_i[b];
    end else begin : g_pass
      assign addr_o[b] = addr_i[b];
    end
  end
endmodule

// File: rtl/rx_addr_override.sv
module rx_addr_override
  import rxao_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              pkt_start_i,
  input  logic              pkt_end_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  ovr_cfg_t shadow_cfg, eff_cfg, act_cfg;
  logic     busy, load;

  rxao_cfg_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (shadow_cfg),
    .rdata_o (reg_rdata_o)
  );

  rxao_pkt_track u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pkt_start_i),
    .end_i   (pkt_end_i),
    .busy_o  (busy)
  );

  assign load = pkt_start_i | ~busy;

  rxao_cfg_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .shadow_i (shadow_cfg),
    .eff_o    (eff_cfg),
    .act_o    (act_cfg)
  );

  rxao_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .addr_i (addr_i),
    .cfg_i  (eff_cfg),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/rxao_checker.sv
module rxao_checker
  import rxao_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pkt_start_i,
  input logic              pkt_end_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              busy,
  input ovr_cfg_t          act_cfg
);
  localparam int OVR_LSB = ADDR_W - OVR_W;

  AST_LOW_BITS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[OVR_LSB-1:0] == addr_i[OVR_LSB-1:0]); // R11

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[VAL_LSB-1:EN_LSB+OVR_W] == '0); // R5

  AST_FROZEN_IN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !pkt_start_i) |=> act_cfg == $past(act_cfg)); // R6

  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_i |=> busy); // R9

  AST_IDLE_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && !pkt_start_i) |=> !busy); // R9
endmodule

bind rx_addr_override rxao_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_start_i (pkt_start_i),
  .pkt_end_i   (pkt_end_i),
  .addr_i      (addr_i),
  .addr_o      (addr_o),
  .reg_rdata_o (reg_rdata_o),
  .busy        (busy),
  .act_cfg     (act_cfg)
);

// File: tb/sim_rx_addr_override.sv
`timescale 1ns/1ps
module sim_rx_addr_override;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        pkt_start_i = 1'b0;
  logic        pkt_end_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] addr_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  // behavioural reference state
  logic [3:0] m_sval = '0, m_sen = '0, m_aval = '0, m_aen = '0;
  bit         m_busy = 0;

  always #2 clk_i = ~clk_i;

  rx_addr_override u0 (.*);

  task automatic step(string tag, bit we, logic [31:0] wd, bit st, bit en, logic [31:0] a);
    logic [3:0]  ev, ee;
    logic [31:0] exp_a, exp_r;
    bit          ld;
    @(negedge clk_i);
    reg_we_i = we; reg_wdata_i = wd; pkt_start_i = st; pkt_end_i = en; addr_i = a;
    #1;
    ld = st || !m_busy;
    ev = ld ? m_sval : m_aval;
    ee = ld ? m_sen : m_aen;
    exp_a = a;
    for (int n = 0; n < 4; n++) if (ee[n]) exp_a[28+n] = ev[n];
    exp_r = {m_sval, 24'h0, m_sen};
    n_vec++;
    if (addr_o !== exp_a) begin
      n_bad++;
      $display("FAIL %s addr_o act=%h exp=%h", tag, addr_o, exp_a);
    end
    if (reg_rdata_o !== exp_r) begin
      n_bad++;
      $display("FAIL %s reg_rdata_o act=%h exp=%h", tag, reg_rdata_o, exp_r);
    end
    @(posedge clk_i);
    if (rst_ni) begin
      m_aval = ev; m_aen = ee;
      if (we) begin m_sval = wd[31:28]; m_sen = wd[3:0]; end
      m_busy = st || (m_busy && !en);
    end
  endtask

  task automatic idle(string tag, int n, logic [31:0] a);
    for (int i = 0; i < n; i++) step(tag, 0, '0, 0, 0, a ^ $urandom);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset state
    step("R1", 0, '0, 0, 0, 32'hFFFF_FFFF);
    step("R1", 0, '0, 0, 0, 32'h1234_5678);
    @(negedge clk_i); rst_ni = 1'b1;
    step("R1", 0, '0, 0, 0, 32'hDEAD_BEEF);
    idle("R11", 3, 32'h0);
    // R2 R3 all enables, value 1010
    step("R2", 1, 32'hA000_000F, 0, 0, 32'h0);
    step("R3", 0, '0, 0, 0, 32'h0000_0000);
    step("R3", 0, '0, 0, 0, 32'hFFFF_FFFF);
    idle("R3", 4, 32'h5555_5555);
    // R4 alternating enables
    step("R4", 1, 32'h5000_0005, 0, 0, 32'h0);
    step("R4", 0, '0, 0, 0, 32'h0000_0000);
    step("R4", 0, '0, 0, 0, 32'hFFFF_FFFF);
    step("R4", 1, 32'hF000_000A, 0, 0, 32'h0);
    step("R4", 0, '0, 0, 0, 32'h0000_0000);
    step("R4", 0, '0, 0, 0, 32'hFFFF_FFFF);
    idle("R4", 3, 32'hAAAA_AAAA);
    // R5 reserved bits only
    step("R5", 1, 32'h0FFF_FFF0, 0, 0, 32'h0);
    step("R5", 0, '0, 0, 0, 32'hFFFF_FFFF);
    step("R5", 0, '0, 0, 0, 32'h0000_0000);
    // R6 R7 R8 write mid-packet
    step("R7", 1, 32'h3000_0003, 0, 0, 32'h0);
    idle("R7", 2, 32'h0);
    step("R6", 0, '0, 1, 0, 32'hFFFF_FFFF);
    step("R6", 0, '0, 0, 0, 32'h0000_0000);
    step("R6", 1, 32'hC000_000C, 0, 0, 32'h0000_0000);
    step("R8", 0, '0, 0, 0, 32'hFFFF_FFFF);
    step("R6", 0, '0, 0, 0, 32'h0000_0000);
    step("R6", 0, '0, 0, 1, 32'hFFFF_FFFF);
    step("R7", 0, '0, 0, 0, 32'h0000_0000);
    step("R7", 0, '0, 1, 0, 32'hFFFF_FFFF);
    step("R7", 0, '0, 0, 0, 32'h0000_0000);
    // R9 back-to-back end and start
    step("R9", 1, 32'h9000_0009, 0, 0, 32'hFFFF_FFFF);
    step("R9", 0, '0, 0, 0, 32'h0000_0000);
    step("R9", 0, '0, 1, 1, 32'h0000_0000);
    step("R9", 0, '0, 0, 0, 32'hFFFF_FFFF);
    step("R9", 1, 32'h6000_0006, 0, 0, 32'h0000_0000);
    step("R9", 0, '0, 0, 0, 32'h0000_0000);
    step("R9", 0, '0, 0, 1, 32'hFFFF_FFFF);
    step("R9", 0, '0, 0, 0, 32'h0000_0000);
    // R10 write in the start cycle
    step("R10", 1, 32'hF000_000F, 1, 0, 32'h0000_0000);
    step("R10", 0, '0, 0, 0, 32'h0000_0000);
    step("R10", 0, '0, 0, 0, 32'hFFFF_FFFF);
    step("R10", 0, '0, 0, 1, 32'h0000_0000);
    step("R10", 0, '0, 0, 0, 32'h0000_0000);
    // R11 random traffic with random packets and writes
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r = $urandom;
      step("R11", r[0] & r[1], $urandom, r[2] & r[3], r[4], $urandom);
    end
    idle("R11", 4, 32'h0);
    summary();
  end
endmodule